// File: doc/BRIEF.md
# Multi-Level Page Table Walker

This block turns a 64-bit virtual address into a 48-bit output address. It reads 64-bit translation descriptors from memory, one per level, for up to four levels. A caller supplies the address, whether the access is a write, and a per-context setup. The setup holds two translation regions: a low region whose upper address bits are zeros and a high region whose upper bits are ones. Each region has a root pointer and a size field. The setup also holds a granule selector and one top-byte-ignore flag per region.

The walker first chooses a region. From the region size and the granule it works out the start level and the root table base. It then issues one descriptor read at a time on a valid/ready request port and waits for the matching response. Each descriptor it receives is a table, block or page entry, or it is invalid or reserved. When the walk ends, the walker reports one of two outcomes. A successful walk returns the output address, the read and write permissions and the granule offset mask. A failed walk returns a fault code, plus the descriptor address when a memory read failed. The results stay stable until the next start.

Top module: `ptw_walker`

## Requirements
- R1: Address bit 55 picks the ignore flag: `hi_tag_ign` when bit 55 is 1, `lo_tag_ign` otherwise. With that flag set, bits 63:56 are excluded from the region test. The low region is used when `lo_size` is nonzero and address bits 63 down to 64-`lo_size` are all zero. Otherwise the high region is used when `hi_size` is nonzero and those bits (counted with `hi_size`) are all one. Otherwise a region whose size is zero takes the address, and the low region is tried first.
- R2: An address that fits neither region raises fault code 1 (translation) with no memory read.
- R3: `gran_sel` 0, 1 and 2 select granules of 4 KiB, 16 KiB and 64 KiB, so G = 12, 14 or 16. The value 3 is reserved and gives fault 1 with no read. The input size is 64 minus the region size and the stride is G-3. The start level is 4 - (input size - 4)/stride. A quotient outside 1..4 gives fault 1 with no read.
- R4: The root base is the region root with its low (input size - stride*(4 - start level)) bits cleared. At level L the descriptor is read at base + 8*index. The index is bits [G+stride*(3-L) +: stride] of the address, after bits at or above the input size have been cleared.
- R5: Descriptor bits 1:0 decide the entry type. Bit 0 clear means invalid. The value 3 is a table at levels 0-2 and a page at level 3. The value 1 is a block at levels 1 and 2 and reserved at levels 0 and 3. Invalid and reserved entries give fault 1.
- R6: A table entry continues the walk from its bits 47:G. A leaf at level L covers 2^(G+stride*(3-L)) bytes. The output address is the descriptor's bits 47 down to that span, plus the address bits below the span.
- R7: Leaf bit 7 marks the entry read-only. A write to such an entry gives fault code 2 (permission). Every success reports `perm_rd`=1 and `perm_wr` equal to the inverse of bit 7.
- R8: Table bit 62 write-protects everything below that table. A write through such a table gives fault 2 with no further reads. A read through it proceeds.
- R9: A response with `mem_rsp_err` set gives fault code 3 (walk abort), and `fault_addr` carries that descriptor's address. For all other outcomes `fault_addr` is 0.
- R10: On a fault, `perm_rd`, `perm_wr`, `out_addr` and `addr_mask` are 0. On success, `addr_mask` is 2^G-1. Fault code 0 means success.
- R11: `done` is a one-cycle pulse. `mem_req_valid` stays high with a stable address until `mem_req_ready` is high, and only one read is outstanding at a time. A `start` during a walk is ignored.
- R12: All result outputs hold their values from `done` until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a walk (accepted when idle) |
| va | input | 64 | Virtual address to translate |
| is_write | input | 1 | 1 for a write access |
| gran_sel | input | 2 | Granule selector |
| lo_size | input | 6 | Low region size field |
| hi_size | input | 6 | High region size field |
| lo_root | input | 48 | Low region root table pointer |
| hi_root | input | 48 | High region root table pointer |
| lo_tag_ign | input | 1 | Top-byte-ignore for bit 55 = 0 |
| hi_tag_ign | input | 1 | Top-byte-ignore for bit 55 = 1 |
| mem_req_valid | output | 1 | Descriptor read request |
| mem_req_ready | input | 1 | Request accepted |
| mem_req_addr | output | 48 | Descriptor byte address |
| mem_rsp_valid | input | 1 | Response present |
| mem_rsp_data | input | 64 | Descriptor value |
| mem_rsp_err | input | 1 | Response carries a read error |
| done | output | 1 | Walk finished (one cycle) |
| fault | output | 2 | 0 none, 1 translation, 2 permission, 3 walk abort |
| out_addr | output | 48 | Translated address |
| perm_rd | output | 1 | Read allowed |
| perm_wr | output | 1 | Write allowed |
| addr_mask | output | 48 | Granule offset mask |
| fault_addr | output | 48 | Descriptor address of a walk abort |

## Verification
The hardest outcomes to produce are those decided partway through a walk. These include a write-protect bit on an intermediate table, a read error on the second descriptor, and a block entry at a level where blocks are reserved. The bench builds real descriptor chains in a sparse memory model for each granule and region size, then marks chosen descriptor addresses as erroring or overwrites their type bits. It counts the reads accepted on the request port, which shows exactly at which level each walk stopped. A second start issued during a live walk, with a different address and access type, shows that the input is ignored.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int VA_W   = 64;
    localparam int PA_W   = 48;
    localparam int LVL_W  = 2;
    localparam int SIZE_W = 6;
    localparam int INSZ_W = 7;
    localparam int G_W    = 5;
    localparam int TAG_LO = 56;   // first bit of the ignorable top byte
    localparam int SEL_BIT = 55;  // picks which ignore flag applies

    typedef enum logic [1:0] {
        FLT_NONE  = 2'd0,
        FLT_TRANS = 2'd1,
        FLT_PERM  = 2'd2,
        FLT_ABORT = 2'd3
    } fault_e;

    typedef enum logic [2:0] {
        DK_INVALID,
        DK_TABLE,
        DK_BLOCK,
        DK_PAGE,
        DK_RESERVED
    } desc_kind_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_REQ,
        S_RSP
    } walk_state_e;

    // log2 of the granule in bytes, 0 marks the reserved encoding
    function automatic logic [G_W-1:0] gran_log2(input logic [1:0] sel);
        case (sel)
            2'd0:    return G_W'(12);
            2'd1:    return G_W'(14);
            2'd2:    return G_W'(16);
            default: return G_W'(0);
        endcase
    endfunction

    // address bits covered below one entry at a level
    function automatic logic [INSZ_W-1:0] level_shift(input logic [G_W-1:0] g,
                                                      input logic [LVL_W-1:0] lvl);
        int s;
        s = int'(g) + (int'(g) - 3) * (3 - int'(lvl));
        return INSZ_W'(s);
    endfunction

    function automatic logic [VA_W-1:0] low_mask(input logic [INSZ_W-1:0] n);
        if (n >= INSZ_W'(VA_W)) return '1;
        return (VA_W'(1) << n) - VA_W'(1);
    endfunction

endpackage

// File: rtl/ptw_region_sel.sv
module ptw_region_sel
    import ptw_pkg::*;
(
    input  logic [VA_W-1:0]   va,
    input  logic [SIZE_W-1:0] lo_size,
    input  logic [SIZE_W-1:0] hi_size,
    input  logic              lo_tag_ign,
    input  logic              hi_tag_ign,
    output logic              hit,
    output logic              use_hi
);
    logic tag_ign;
    logic lo_match;
    logic hi_match;
    int   top;

    always_comb begin
        tag_ign  = va[SEL_BIT] ? hi_tag_ign : lo_tag_ign;
        top      = tag_ign ? TAG_LO : VA_W;
        lo_match = 1'b1;
        hi_match = 1'b1;
        for (int i = 0; i < VA_W; i++) begin
            if (i >= VA_W - int'(lo_size) && i < top && va[i])
                lo_match = 1'b0;
            if (i >= VA_W - int'(hi_size) && i < top && !va[i])
                hi_match = 1'b0;
        end
        hit    = 1'b1;
        use_hi = 1'b0;
        if (lo_size != '0 && lo_match) begin
            use_hi = 1'b0;
        end else if (hi_size != '0 && hi_match) begin
            use_hi = 1'b1;
        end else if (lo_size == '0) begin
            use_hi = 1'b0;
        end else if (hi_size == '0) begin
            use_hi = 1'b1;
        end else begin
            hit = 1'b0;
        end
    end
endmodule

// File: rtl/ptw_start_calc.sv
module ptw_start_calc
    import ptw_pkg::*;
(
    input  logic [1:0]        gran_sel,
    input  logic [SIZE_W-1:0] size,
    input  logic [PA_W-1:0]   root,
    output logic              ok,
    output logic [G_W-1:0]    glog,
    output logic [LVL_W-1:0]  start_lvl,
    output logic [INSZ_W-1:0] insz,
    output logic [PA_W-1:0]   root_base
);
    int g;
    int stride;
    int isz;
    int quot;
    int w;
    logic [VA_W-1:0] clr;
    logic unused_clr_hi;

    always_comb begin
        glog   = gran_log2(gran_sel);
        g      = int'(glog);
        stride = g - 3;
        isz    = VA_W - int'(size);
        quot   = 0;
        ok     = 1'b0;
        if (g != 0 && isz >= 4) begin
            quot = (isz - 4) / stride;
            ok   = (quot >= 1) && (quot <= 4);
        end
        start_lvl = ok ? LVL_W'(4 - quot) : '0;
        w         = ok ? isz - stride * quot : 0;
        clr       = low_mask(INSZ_W'(w));
        root_base = root & ~clr[PA_W-1:0];
        insz      = INSZ_W'(isz);
    end

    assign unused_clr_hi = ^clr[VA_W-1:PA_W];
endmodule

// File: rtl/ptw_desc_decode.sv
module ptw_desc_decode
    import ptw_pkg::*;
(
    input  logic [1:0]       type_bits,
    input  logic [LVL_W-1:0] level,
    output desc_kind_e       kind
);
    always_comb begin
        case (type_bits)
            2'b11:   kind = (level == LVL_W'(3)) ? DK_PAGE : DK_TABLE;
            2'b01:   kind = (level == LVL_W'(1) || level == LVL_W'(2)) ? DK_BLOCK : DK_RESERVED;
            default: kind = DK_INVALID;
        endcase
    end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int RO_BIT = 7,
    parameter int WP_BIT = 62
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [VA_W-1:0]   va,
    input  logic              is_write,
    input  logic [1:0]        gran_sel,
    input  logic [SIZE_W-1:0] lo_size,
    input  logic [SIZE_W-1:0] hi_size,
    input  logic [PA_W-1:0]   lo_root,
    input  logic [PA_W-1:0]   hi_root,
    input  logic              lo_tag_ign,
    input  logic              hi_tag_ign,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [PA_W-1:0]   mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [63:0]       mem_rsp_data,
    input  logic              mem_rsp_err,
    output logic              done,
    output logic [1:0]        fault,
    output logic [PA_W-1:0]   out_addr,
    output logic              perm_rd,
    output logic              perm_wr,
    output logic [PA_W-1:0]   addr_mask,
    output logic [PA_W-1:0]   fault_addr
);
    walk_state_e       st_q;
    logic [LVL_W-1:0]  lvl_q;
    logic [PA_W-1:0]   base_q;
    logic [VA_W-1:0]   va_q;
    logic              wr_q;
    logic [G_W-1:0]    glog_q;
    logic [INSZ_W-1:0] insz_q;

    logic              done_q;
    fault_e            fault_q;
    logic [PA_W-1:0]   out_q;
    logic              rd_q;
    logic              wrp_q;
    logic [PA_W-1:0]   mask_q;
    logic [PA_W-1:0]   faddr_q;

    logic              sel_hit;
    logic              sel_hi;
    logic              st_ok;
    logic [G_W-1:0]    st_glog;
    logic [LVL_W-1:0]  st_lvl;
    logic [INSZ_W-1:0] st_insz;
    logic [PA_W-1:0]   st_root;
    desc_kind_e        kind;

    ptw_region_sel u_sel (
        .va         (va),
        .lo_size    (lo_size),
        .hi_size    (hi_size),
        .lo_tag_ign (lo_tag_ign),
        .hi_tag_ign (hi_tag_ign),
        .hit        (sel_hit),
        .use_hi     (sel_hi)
    );

    ptw_start_calc u_start (
        .gran_sel  (gran_sel),
        .size      (sel_hi ? hi_size : lo_size),
        .root      (sel_hi ? hi_root : lo_root),
        .ok        (st_ok),
        .glog      (st_glog),
        .start_lvl (st_lvl),
        .insz      (st_insz),
        .root_base (st_root)
    );

    ptw_desc_decode u_dec (
        .type_bits (mem_rsp_data[1:0]),
        .level     (lvl_q),
        .kind      (kind)
    );

    // index and span for the current level
    logic [INSZ_W-1:0] shift;
    logic [VA_W-1:0]   lm_insz;
    logic [VA_W-1:0]   lm_stride;
    logic [VA_W-1:0]   lm_span;
    logic [VA_W-1:0]   lm_gran;
    logic [VA_W-1:0]   idx;
    logic [PA_W-1:0]   desc_addr;
    logic [PA_W-1:0]   leaf_addr;
    logic [PA_W-1:0]   next_base;
    logic              ro_bit;
    logic              wp_bit;
    logic              unused_bits;

    always_comb begin
        shift     = level_shift(glog_q, lvl_q);
        lm_insz   = low_mask(insz_q);
        lm_stride = low_mask(INSZ_W'(glog_q - G_W'(3)));
        lm_span   = low_mask(shift);
        lm_gran   = low_mask(INSZ_W'(glog_q));
        idx       = ((va_q & lm_insz) >> shift) & lm_stride;
        desc_addr = base_q + PA_W'(idx << 3);
        leaf_addr = (mem_rsp_data[PA_W-1:0] & ~lm_span[PA_W-1:0])
                  + (va_q[PA_W-1:0] & lm_span[PA_W-1:0]);
        next_base = mem_rsp_data[PA_W-1:0] & ~lm_gran[PA_W-1:0];
        ro_bit    = mem_rsp_data[RO_BIT];
        wp_bit    = mem_rsp_data[WP_BIT];
    end

    assign unused_bits = ^{mem_rsp_data[63], mem_rsp_data[61:PA_W],
                           lm_span[VA_W-1:PA_W], lm_gran[VA_W-1:PA_W]};

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= S_IDLE;
            lvl_q   <= '0;
            base_q  <= '0;
            va_q    <= '0;
            wr_q    <= 1'b0;
            glog_q  <= G_W'(12);
            insz_q  <= '0;
            done_q  <= 1'b0;
            fault_q <= FLT_NONE;
            out_q   <= '0;
            rd_q    <= 1'b0;
            wrp_q   <= 1'b0;
            mask_q  <= '0;
            faddr_q <= '0;
        end else begin
            done_q <= 1'b0;
            case (st_q)
                S_IDLE: begin
                    if (start) begin
                        va_q    <= va;
                        wr_q    <= is_write;
                        fault_q <= FLT_NONE;
                        out_q   <= '0;
                        rd_q    <= 1'b0;
                        wrp_q   <= 1'b0;
                        mask_q  <= '0;
                        faddr_q <= '0;
                        if (!sel_hit || !st_ok) begin
                            fault_q <= FLT_TRANS;
                            done_q  <= 1'b1;
                        end else begin
                            base_q <= st_root;
                            lvl_q  <= st_lvl;
                            glog_q <= st_glog;
                            insz_q <= st_insz;
                            st_q   <= S_REQ;
                        end
                    end
                end
                S_REQ: begin
                    if (mem_req_ready) st_q <= S_RSP;
                end
                S_RSP: begin
                    if (mem_rsp_valid) begin
                        if (mem_rsp_err) begin
                            fault_q <= FLT_ABORT;
                            faddr_q <= desc_addr;
                            done_q  <= 1'b1;
                            st_q    <= S_IDLE;
                        end else begin
                            case (kind)
                                DK_TABLE: begin
                                    if (wr_q && wp_bit) begin
                                        fault_q <= FLT_PERM;
                                        done_q  <= 1'b1;
                                        st_q    <= S_IDLE;
                                    end else begin
                                        base_q <= next_base;
                                        lvl_q  <= lvl_q + LVL_W'(1);
                                        st_q   <= S_REQ;
                                    end
                                end
                                DK_BLOCK, DK_PAGE: begin
                                    if (wr_q && ro_bit) begin
                                        fault_q <= FLT_PERM;
                                    end else begin
                                        out_q  <= leaf_addr;
                                        rd_q   <= 1'b1;
                                        wrp_q  <= !ro_bit;
                                        mask_q <= lm_gran[PA_W-1:0];
                                    end
                                    done_q <= 1'b1;
                                    st_q   <= S_IDLE;
                                end
                                default: begin
                                    fault_q <= FLT_TRANS;
                                    done_q  <= 1'b1;
                                    st_q    <= S_IDLE;
                                end
                            endcase
                        end
                    end
                end
                default: st_q <= S_IDLE;
            endcase
        end
    end

    assign mem_req_valid = (st_q == S_REQ);
    assign mem_req_addr  = desc_addr;
    assign done          = done_q;
    assign fault         = fault_q;
    assign out_addr      = out_q;
    assign perm_rd       = rd_q;
    assign perm_wr       = wrp_q;
    assign addr_mask     = mask_q;
    assign fault_addr    = faddr_q;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R11

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R11

    AST_FAULT_NO_PERM: assert property (@(posedge clk) disable iff (rst)
        (done && fault != 2'd0) |-> (!perm_rd && !perm_wr && addr_mask == '0)); // R10

    AST_SUCCESS_READ: assert property (@(posedge clk) disable iff (rst)
        (done && fault == 2'd0) |-> perm_rd); // R7

    AST_LEVEL_STEP: assert property (@(posedge clk) disable iff (rst)
        (st_q == S_REQ && $past(st_q) == S_RSP) |-> (lvl_q == $past(lvl_q) + LVL_W'(1))); // R6

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (st_q == S_IDLE && !start) |=> ($stable(fault) && $stable(out_addr) && $stable(fault_addr))); // R12

endmodule

// File: tb/ptw_walker_tb.sv
`timescale 1ns/1ps
module ptw_walker_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [63:0] va = '0;
    logic is_write = 1'b0;
    logic [1:0] gran_sel = '0;
    logic [5:0] lo_size = 6'd16;
    logic [5:0] hi_size = 6'd16;
    logic [47:0] lo_root = 48'h0030_0000_0008;
    logic [47:0] hi_root = 48'h0031_0000_0005;
    logic lo_tag_ign = 1'b0;
    logic hi_tag_ign = 1'b0;
    logic mem_req_valid;
    logic mem_req_ready;
    logic [47:0] mem_req_addr;
    logic mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic mem_rsp_err = 1'b0;
    logic done;
    logic [1:0] fault;
    logic [47:0] out_addr;
    logic perm_rd;
    logic perm_wr;
    logic [47:0] addr_mask;
    logic [47:0] fault_addr;

    ptw_walker u_dut (
        .clk(clk), .rst(rst), .start(start), .va(va), .is_write(is_write),
        .gran_sel(gran_sel), .lo_size(lo_size), .hi_size(hi_size),
        .lo_root(lo_root), .hi_root(hi_root),
        .lo_tag_ign(lo_tag_ign), .hi_tag_ign(hi_tag_ign),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err),
        .done(done), .fault(fault), .out_addr(out_addr),
        .perm_rd(perm_rd), .perm_wr(perm_wr), .addr_mask(addr_mask),
        .fault_addr(fault_addr)
    );

    always #2.5 clk = ~clk;

    localparam logic [63:0] JUNK   = 64'h0010_0000_0000_0400;
    localparam logic [47:0] PA_PAT = 48'hB5A3_7C1E_9000;

    logic [63:0] mem [logic [47:0]];
    bit          errs [logic [47:0]];
    logic [47:0] nxt;
    int nreq = 0;
    int nchk = 0;
    int nfail = 0;
    logic [2:0] rdy_ctr = '0;
    logic pend = 1'b0;
    logic [47:0] pend_addr = '0;

    assign mem_req_ready = (rdy_ctr[1:0] != 2'b01);

    // memory model: one-cycle turnaround after acceptance
    always @(posedge clk) begin
        rdy_ctr <= rdy_ctr + 3'd1;
        mem_rsp_valid <= 1'b0;
        if (pend) begin
            mem_rsp_valid <= 1'b1;
            mem_rsp_data  <= mem.exists(pend_addr) ? mem[pend_addr] : 64'd0;
            mem_rsp_err   <= errs.exists(pend_addr);
            pend <= 1'b0;
        end
        if (mem_req_valid && mem_req_ready) begin
            pend      <= 1'b1;
            pend_addr <= mem_req_addr;
            nreq      <= nreq + 1;
        end
    end

    logic [1:0]  r_fault;
    logic [47:0] r_out, r_mask, r_faddr;
    logic        r_rd, r_wr;
    int          r_reads;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int glog(input int gs); return 12 + 2 * gs; endfunction
    function automatic int shf(input int g, input int l); return g + (g - 3) * (3 - l); endfunction
    function automatic int stl(input int g, input int sz); return 4 - ((64 - sz) - 4) / (g - 3); endfunction
    function automatic logic [63:0] msk(input int n);
        if (n >= 64) return '1;
        return (64'd1 << n) - 64'd1;
    endfunction

    task automatic clr_mem();
        mem.delete();
        errs.delete();
        nxt = 48'h0040_0000_0000;
    endtask

    // lays out a chain from the start level down to 'leaf'
    task automatic build(input int g, input int sz, input logic [47:0] root, input logic [63:0] v,
                         input int leaf, input logic [47:0] pa, input bit ro, input int wp_lvl,
                         input int mark_lvl, output logic [47:0] mark_addr);
        int sl;
        logic [63:0] m;
        logic [47:0] base, a;
        logic [63:0] ix;
        sl = stl(g, sz);
        m = msk(64 - sz - (g - 3) * (4 - sl));
        base = root & ~m[47:0];
        mark_addr = '0;
        for (int l = sl; l <= leaf; l++) begin
            ix = ((v & msk(64 - sz)) >> shf(g, l)) & msk(g - 3);
            a = base + ix[44:0] * 48'd8;
            if (l == mark_lvl) mark_addr = a;
            if (l < leaf) begin
                mem[a] = {16'd0, nxt} | 64'd3 | JUNK | ((l == wp_lvl) ? (64'd1 << 62) : 64'd0);
                base = nxt;
                nxt = nxt + 48'h1_0000;
            end else begin
                mem[a] = {16'd0, pa} | ((leaf == 3) ? 64'd3 : 64'd1) | JUNK | (ro ? 64'h80 : 64'd0);
            end
        end
    endtask

    task automatic walk(input logic [63:0] v, input bit w, input bit interfere);
        int n0;
        int t;
        @(negedge clk);
        va = v; is_write = w; start = 1'b1; n0 = nreq;
        @(negedge clk);
        start = 1'b0;
        if (interfere) begin
            va = ~v; is_write = ~w; start = 1'b1;
            @(negedge clk);
            start = 1'b0; va = v; is_write = w;
        end
        t = 0;
        while (!done && t < 400) begin
            @(negedge clk);
            t++;
        end
        chk(done, "R11 done seen", {63'd0, done}, 64'd1);
        r_fault = fault; r_out = out_addr; r_mask = addr_mask; r_faddr = fault_addr;
        r_rd = perm_rd; r_wr = perm_wr; r_reads = nreq - n0;
    endtask

    task automatic expect_ok(input string req, input logic [47:0] exp_out, input bit exp_wr,
                             input int g, input int reads);
        chk(r_fault == 2'd0, req, {62'd0, r_fault}, 64'd0);
        chk(r_out == exp_out, req, {16'd0, r_out}, {16'd0, exp_out});
        chk(r_rd && r_wr == exp_wr, req, {62'd0, r_rd, r_wr}, {62'd0, 1'b1, exp_wr});
        chk(r_mask == msk(g), "R10 mask", {16'd0, r_mask}, msk(g));
        chk(r_reads == reads, req, r_reads, reads);
    endtask

    task automatic expect_flt(input string req, input logic [1:0] code, input int reads);
        chk(r_fault == code, req, {62'd0, r_fault}, {62'd0, code});
        chk(!r_rd && !r_wr && r_mask == '0 && r_out == '0, "R10 no perm on fault",
            {r_mask, 14'd0, r_rd, r_wr}, 64'd0);
        chk(r_reads == reads, req, r_reads, reads);
    endtask

    initial begin
        #(200000 * 5);
        nfail++;
        $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
        $display("[TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end

    initial begin
        logic [47:0] mk;
        logic [63:0] v;
        int k;
        repeat (4) @(negedge clk);
        chk(!done && !mem_req_valid && fault == 2'd0 && out_addr == '0 && fault_addr == '0,
            "R12 reset state", {done, mem_req_valid, fault, out_addr}, 64'd0);
        rst = 1'b0;

        // sweep: granules, region sizes, leaf levels, access and read-only
        k = 0;
        for (int gs = 0; gs < 3; gs++) begin
            for (int ti = 0; ti < 2; ti++) begin
                for (int leaf = 1; leaf <= 3; leaf++) begin
                    for (int w = 0; w < 2; w++) begin
                        for (int ro = 0; ro < 2; ro++) begin
                            int g, sz, sl, sp;
                            logic [63:0] pm;
                            g = glog(gs); sz = ti ? 25 : 16; sl = stl(g, sz);
                            if (leaf >= sl) begin
                                k++;
                                sp = shf(g, leaf);
                                pm = msk(sp);
                                v = (64'h0000_F3A5_96C3_5E71 ^ (64'(k) * 64'h1_0203_0405)) & msk(64 - sz);
                                clr_mem();
                                gran_sel = 2'(gs); lo_size = 6'(sz); hi_size = 6'(sz);
                                build(g, sz, lo_root, v, leaf, PA_PAT & ~pm[47:0], ro[0], -1, -1, mk);
                                walk(v, w[0], 1'b0);
                                if (w == 1 && ro == 1)
                                    expect_flt("R7 write to read-only leaf", 2'd2, leaf - sl + 1);
                                else
                                    expect_ok("R6 R4 R3 leaf translation",
                                              (PA_PAT & ~pm[47:0]) + (v[47:0] & pm[47:0]),
                                              ~ro[0], g, leaf - sl + 1);
                            end
                        end
                    end
                end
            end
        end

        // high region
        clr_mem(); gran_sel = 2'd0; lo_size = 6'd16; hi_size = 6'd16;
        v = 64'hFFFF_8123_4567_89AB;
        build(12, 16, hi_root, v, 3, 48'h0000_7777_A000, 1'b0, -1, -1, mk);
        walk(v, 1'b1, 1'b0);
        expect_ok("R1 high region", 48'h0000_7777_A9AB, 1'b1, 12, 4);

        // gap between regions
        walk(64'h00F0_0000_0000_1000, 1'b0, 1'b0);
        expect_flt("R2 gap fault", 2'd1, 0);

        // low region flag, bit 55 = 0
        clr_mem(); lo_tag_ign = 1'b1; hi_tag_ign = 1'b0;
        v = 64'hA500_0012_3456_7000;
        build(12, 16, lo_root, v, 3, 48'h0000_1234_5000, 1'b0, -1, -1, mk);
        walk(v, 1'b0, 1'b0);
        expect_ok("R1 low ignore flag", 48'h0000_1234_5000, 1'b1, 12, 4);
        lo_tag_ign = 1'b0;
        walk(v, 1'b0, 1'b0);
        expect_flt("R1 top byte checked without flag", 2'd1, 0);

        // bit 55 picks the high flag
        clr_mem(); lo_tag_ign = 1'b0; hi_tag_ign = 1'b1;
        v = 64'h3CFF_FF80_0000_2468;
        build(12, 16, hi_root, v, 3, 48'h0000_5555_6000, 1'b0, -1, -1, mk);
        walk(v, 1'b0, 1'b0);
        expect_ok("R1 bit55 selects high flag", 48'h0000_5555_6468, 1'b1, 12, 4);
        lo_tag_ign = 1'b1; hi_tag_ign = 1'b0;
        walk(v, 1'b0, 1'b0);
        expect_flt("R1 bit55 ignores low flag", 2'd1, 0);
        lo_tag_ign = 1'b0;

        // zero-size low region takes everything else, 64 KiB granule, start level 0
        clr_mem(); gran_sel = 2'd2; lo_size = 6'd0; hi_size = 6'd25;
        v = 64'h1234_5678_9ABC_DEF0;
        build(16, 0, lo_root, v, 1, 48'h8000_0000_0000, 1'b0, -1, -1, mk);
        walk(v, 1'b1, 1'b0);
        expect_ok("R1 zero size fallback", 48'h8000_0000_0000 + (v[47:0] & 48'h03FF_FFFF_FFFF), 1'b1, 16, 2);

        // reserved granule and start level out of range
        gran_sel = 2'd3; lo_size = 6'd16; hi_size = 6'd16;
        walk(64'h0000_0000_0000_1000, 1'b0, 1'b0);
        expect_flt("R3 reserved granule", 2'd1, 0);
        gran_sel = 2'd0; lo_size = 6'd60;
        walk(64'h0, 1'b0, 1'b0);
        expect_flt("R3 start level out of range", 2'd1, 0);

        // invalid descriptor
        clr_mem(); lo_size = 6'd25;
        walk(64'h0000_0001_2345_6000, 1'b0, 1'b0);
        expect_flt("R5 invalid descriptor", 2'd1, 1);
        chk(r_faddr == '0, "R9 no fault address", {16'd0, r_faddr}, 64'd0);

        // block encoding at level 3 is reserved
        clr_mem(); v = 64'h0000_0001_2345_6000;
        build(12, 25, lo_root, v, 3, 48'h0000_2222_3000, 1'b0, -1, 3, mk);
        mem[mk] = {mem[mk][63:2], 2'b01};
        walk(v, 1'b0, 1'b0);
        expect_flt("R5 level3 block reserved", 2'd1, 3);

        // block at level 0 is reserved
        clr_mem(); lo_size = 6'd16; v = 64'h0000_0012_3456_7000;
        build(12, 16, lo_root, v, 0, 48'h0, 1'b0, -1, -1, mk);
        walk(v, 1'b0, 1'b0);
        expect_flt("R5 level0 block reserved", 2'd1, 1);

        // table write-protect
        clr_mem(); gran_sel = 2'd1; v = 64'h0000_0ABC_DEF1_2340;
        build(14, 16, lo_root, v, 3, 48'h0000_6666_8000, 1'b0, 1, -1, mk);
        walk(v, 1'b1, 1'b0);
        expect_flt("R8 table write protect", 2'd2, 2);
        walk(v, 1'b0, 1'b0);
        expect_ok("R8 read through protected table", 48'h0000_6666_8000 + (v[47:0] & 48'h3FFF), 1'b1, 14, 4);

        // read error at the second descriptor
        clr_mem(); gran_sel = 2'd0; lo_size = 6'd25; v = 64'h0000_0001_2345_6000;
        build(12, 25, lo_root, v, 3, 48'h0000_2222_3000, 1'b0, -1, 2, mk);
        errs[mk] = 1'b1;
        walk(v, 1'b0, 1'b0);
        expect_flt("R9 walk abort", 2'd3, 2);
        chk(r_faddr == mk, "R9 fault address", {16'd0, r_faddr}, {16'd0, mk});

        // start during a walk is ignored; results held afterwards
        clr_mem(); lo_size = 6'd16; v = 64'h0000_0044_5566_7123;
        build(12, 16, lo_root, v, 3, 48'h0000_9999_0000, 1'b1, -1, -1, mk);
        walk(v, 1'b0, 1'b1);
        expect_ok("R11 start while busy ignored", 48'h0000_9999_0123, 1'b0, 12, 4);
        repeat (6) @(negedge clk);
        chk(out_addr == r_out && fault == r_fault && perm_rd == r_rd && addr_mask == r_mask,
            "R12 results held", {16'd0, out_addr}, {16'd0, r_out});

        $display("[TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end
endmodule